// File: doc/BRIEF.md
# Character LCD Hex Value Display Controller

This block drives a character LCD module that has a write-only parallel bus: a register-select line, a read/write line, an enable strobe and an 8-bit data bus. After reset it waits for the panel to power up. It then sends a fixed set of configuration instructions, each followed by a settling pause. Once that is done, the block stays idle until a client presents a 16-bit value with a one-cycle start pulse.

For each accepted value, the block first sends the return-home instruction and waits the long delay, so the new text lands in the same screen cells as the previous text. It then turns each 4-bit nibble into an uppercase hexadecimal ASCII character and writes the four characters, highest nibble first. A busy output covers the whole time the block cannot accept a value. Both delays come from a clock-frequency parameter, so a test can use short values.

Top module: `lcd_hex_ctrl`

## Requirements
- R1: While reset is asserted and right after it, busy is 1, lcd_e is 0 and lcd_rw is 0. The first enable pulse does not start until at least the long delay (LONG_MS milliseconds of clock cycles) has passed since reset was released.
- R2: The start-up sequence is four instruction writes with lcd_rs = 0, carrying the bytes 0x3C, 0x0F, 0x01 and 0x06 in that order.
- R3: After each write, other than the return-home write, at least the short delay (SHORT_MS milliseconds of clock cycles) passes between the falling edge of lcd_e and the next rising edge.
- R4: Every write holds lcd_e high for exactly E_CYCLES clock cycles (default 7).
- R5: lcd_rs and lcd_data are stable on the clock before lcd_e rises, while lcd_e is high, and on the clock after lcd_e falls.
- R6: Each accepted value starts with an instruction write (lcd_rs = 0) of 0x02. At least the long delay then passes before the first character write.
- R7: After the return-home write come four data writes with lcd_rs = 1, carrying value[15:12], value[11:8], value[7:4] and value[3:0] in that order.
- R8: A nibble n from 0 to 9 is sent as 0x30 + n. A nibble from 10 to 15 is sent as 0x41 + (n - 10), which gives the characters 'A' to 'F'.
- R9: busy is 0 only when the block is idle. It rises on the clock after a start is accepted and stays high until the delay after the fourth character has run out.
- R10: A start pulse that arrives while busy is 1 is dropped. It does not change the characters being sent, and no writes follow once the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Pulse high for one cycle to request display of value |
| value | input | 16 | Word to display, sampled when start is accepted |
| busy | output | 1 | High while initialising or sending a value |
| lcd_rs | output | 1 | Register select: 0 for an instruction, 1 for a character |
| lcd_rw | output | 1 | Read/write select, held low (write only) |
| lcd_e | output | 1 | Enable strobe |
| lcd_data | output | 8 | Data bus to the panel |

## Verification
The bench records every enable pulse at the pins. It checks each byte, the select level, the pulse width, and the gap from the previous falling edge. The values it sends sit on the 9/A nibble boundary and at all-zero and all-ones. A design with an off-by-one offset in the ASCII conversion would show punctuation characters instead of A-F, and a design that reversed the nibble order would print the word backwards. The bench also checks that the first instruction and the first character each wait at least the long delay, because a controller that hurries the panel during start-up or after return-home loses characters. Finally, it sends a start while the block is busy. A design that queued that request, or latched its value part-way through a word, would show mixed characters or extra writes.

// File: rtl/lcd_hex_pkg.sv
package lcd_hex_pkg;

    // Top-level sequencer states
    typedef enum logic [2:0] {
        SQ_BOOT,
        SQ_SEND,
        SQ_XFER,
        SQ_DLY,
        SQ_IDLE
    } sq_state_e;

    // What the current write belongs to
    typedef enum logic [1:0] {
        OP_BOOT,
        OP_INIT,
        OP_HOME,
        OP_CHAR
    } op_kind_e;

    // Bus writer states
    typedef enum logic [1:0] {
        WR_IDLE,
        WR_SETUP,
        WR_PULSE,
        WR_HOLD
    } wr_state_e;

    // One transfer to the panel
    typedef struct packed {
        logic       rs;
        logic [7:0] byte_v;
    } lcd_xfer_t;

    localparam int          N_INIT_CMDS = 4;
    localparam int          N_DIGITS    = 4;
    localparam logic [7:0]  CMD_HOME    = 8'h02;

    // Power-up instruction list, in the order the panel needs them
    function automatic logic [7:0] init_cmd(input logic [1:0] step);
        logic [7:0] r;
        case (step)
            2'd0:    r = 8'h3C;   // 8-bit bus, two lines
            2'd1:    r = 8'h0F;   // display, cursor, blink on
            2'd2:    r = 8'h01;   // clear
            default: r = 8'h06;   // increment, no shift
        endcase
        return r;
    endfunction

    // Nibble number 'pos' counted from the most significant end
    function automatic logic [3:0] pick_nibble(input logic [15:0] w, input logic [1:0] pos);
        logic [3:0] r;
        case (pos)
            2'd0:    r = w[15:12];
            2'd1:    r = w[11:8];
            2'd2:    r = w[7:4];
            default: r = w[3:0];
        endcase
        return r;
    endfunction

    // Hex digit to uppercase ASCII
    function automatic logic [7:0] nib_to_ascii(input logic [3:0] n);
        logic [7:0] r;
        if (n <= 4'd9) r = {4'h0, n} + 8'h30;
        else           r = {4'h0, n} + 8'h37;
        return r;
    endfunction

endpackage

// File: rtl/lcd_delay_timer.sv
module lcd_delay_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // The counter rests at zero until it is reloaded
    p_rest_at_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q == '0) |=> (cnt_q == '0));

    // Without a reload the counter steps down by exactly one
    p_step_down_r3: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/lcd_bus_writer.sv
module lcd_bus_writer
    import lcd_hex_pkg::*;
#(
    parameter int E_CYCLES = 7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  lcd_xfer_t  xfer,
    output logic       busy,
    output logic       done,
    output logic       lcd_e,
    output logic       lcd_rs,
    output logic [7:0] lcd_data
);

    localparam int CNT_W = $clog2(E_CYCLES + 1);

    wr_state_e        st_q;
    logic [CNT_W-1:0] cnt_q;
    logic             e_q;
    logic             rs_q;
    logic [7:0]       data_q;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= WR_IDLE;
            cnt_q  <= '0;
            e_q    <= 1'b0;
            rs_q   <= 1'b0;
            data_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                WR_IDLE: begin
                    if (go) begin
                        rs_q   <= xfer.rs;
                        data_q <= xfer.byte_v;
                        st_q   <= WR_SETUP;
                    end
                end
                WR_SETUP: begin
                    e_q   <= 1'b1;
                    cnt_q <= '0;
                    st_q  <= WR_PULSE;
                end
                WR_PULSE: begin
                    if (cnt_q == CNT_W'(E_CYCLES - 1)) begin
                        e_q  <= 1'b0;
                        st_q <= WR_HOLD;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                WR_HOLD: begin
                    done_q <= 1'b1;
                    st_q   <= WR_IDLE;
                end
                default: st_q <= WR_IDLE;
            endcase
        end
    end

    assign busy     = (st_q != WR_IDLE);
    assign done     = done_q;
    assign lcd_e    = e_q;
    assign lcd_rs   = rs_q;
    assign lcd_data = data_q;

    // Length of the current enable pulse, kept for the width check
    logic [7:0] hi_run_q;
    always_ff @(posedge clk) begin
        if (rst)        hi_run_q <= '0;
        else if (lcd_e) hi_run_q <= hi_run_q + 1'b1;
        else            hi_run_q <= '0;
    end

    p_enable_width_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(lcd_e) |-> (hi_run_q == 8'(E_CYCLES)));

    p_setup_before_rise_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(lcd_e) |-> ($stable(lcd_data) && $stable(lcd_rs)));

    p_stable_while_high_r5: assert property (@(posedge clk) disable iff (rst)
        (lcd_e && $past(lcd_e)) |-> ($stable(lcd_data) && $stable(lcd_rs)));

    p_hold_after_fall_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(lcd_e) |=> ($stable(lcd_data) && $stable(lcd_rs)));

endmodule

// File: rtl/lcd_hex_seq.sv
module lcd_hex_seq
    import lcd_hex_pkg::*;
#(
    parameter int DLY_W     = 16,
    parameter int LONG_CYC  = 3000,
    parameter int SHORT_CYC = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [15:0]      value,
    output logic             busy,
    output logic             wr_go,
    output lcd_xfer_t        xfer,
    input  logic             wr_done,
    output logic             tmr_load,
    output logic [DLY_W-1:0] tmr_val,
    input  logic             tmr_expired
);

    sq_state_e   st_q;
    op_kind_e    kind_q;
    logic [1:0]  idx_q;
    logic [15:0] val_q;

    localparam logic [1:0] LAST_INIT  = 2'(N_INIT_CMDS - 1);
    localparam logic [1:0] LAST_DIGIT = 2'(N_DIGITS - 1);

    // Byte and select level of the write in progress
    always_comb begin
        xfer = '0;
        case (kind_q)
            OP_INIT: begin
                xfer.rs     = 1'b0;
                xfer.byte_v = init_cmd(idx_q);
            end
            OP_HOME: begin
                xfer.rs     = 1'b0;
                xfer.byte_v = CMD_HOME;
            end
            OP_CHAR: begin
                xfer.rs     = 1'b1;
                xfer.byte_v = nib_to_ascii(pick_nibble(val_q, idx_q));
            end
            default: xfer = '0;
        endcase
    end

    // Delay selection: long after power-up and return-home, short elsewhere
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = DLY_W'(SHORT_CYC);
        if (st_q == SQ_BOOT) begin
            tmr_load = 1'b1;
            tmr_val  = DLY_W'(LONG_CYC);
        end else if (st_q == SQ_XFER && wr_done) begin
            tmr_load = 1'b1;
            tmr_val  = (kind_q == OP_HOME) ? DLY_W'(LONG_CYC) : DLY_W'(SHORT_CYC);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SQ_BOOT;
            kind_q <= OP_BOOT;
            idx_q  <= '0;
            val_q  <= '0;
        end else begin
            case (st_q)
                SQ_BOOT: st_q <= SQ_DLY;
                SQ_SEND: st_q <= SQ_XFER;
                SQ_XFER: if (wr_done) st_q <= SQ_DLY;
                SQ_DLY: begin
                    if (tmr_expired) begin
                        case (kind_q)
                            OP_BOOT: begin
                                kind_q <= OP_INIT;
                                idx_q  <= '0;
                                st_q   <= SQ_SEND;
                            end
                            OP_INIT: begin
                                if (idx_q == LAST_INIT) begin
                                    st_q <= SQ_IDLE;
                                end else begin
                                    idx_q <= idx_q + 1'b1;
                                    st_q  <= SQ_SEND;
                                end
                            end
                            OP_HOME: begin
                                kind_q <= OP_CHAR;
                                idx_q  <= '0;
                                st_q   <= SQ_SEND;
                            end
                            default: begin
                                if (idx_q == LAST_DIGIT) begin
                                    st_q <= SQ_IDLE;
                                end else begin
                                    idx_q <= idx_q + 1'b1;
                                    st_q  <= SQ_SEND;
                                end
                            end
                        endcase
                    end
                end
                SQ_IDLE: begin
                    if (start) begin
                        val_q  <= value;
                        kind_q <= OP_HOME;
                        idx_q  <= '0;
                        st_q   <= SQ_SEND;
                    end
                end
                default: st_q <= SQ_BOOT;
            endcase
        end
    end

    assign busy  = (st_q != SQ_IDLE);
    assign wr_go = (st_q == SQ_SEND);

    // A request made while busy leaves the latched word alone
    p_latched_word_kept_r10: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(val_q));

    // An accepted request raises busy on the next clock
    p_accept_raises_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    // Character writes come only from the digit phase, with the select line high
    p_char_select_high_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_go && kind_q == OP_CHAR) |-> xfer.rs);

endmodule

// File: rtl/lcd_hex_ctrl.sv
module lcd_hex_ctrl
    import lcd_hex_pkg::*;
#(
    parameter int CLK_HZ   = 50_000_000,
    parameter int LONG_MS  = 30,
    parameter int SHORT_MS = 1,
    parameter int E_CYCLES = 7
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [15:0] value,
    output logic        busy,
    output logic        lcd_rs,
    output logic        lcd_rw,
    output logic        lcd_e,
    output logic [7:0]  lcd_data
);

    localparam int CYC_PER_MS = CLK_HZ / 1000;
    localparam int LONG_CYC   = CYC_PER_MS * LONG_MS;
    localparam int SHORT_CYC  = CYC_PER_MS * SHORT_MS;
    localparam int DLY_W      = $clog2(LONG_CYC + 1);

    logic             wr_go;
    logic             wr_busy;
    logic             wr_done;
    lcd_xfer_t        xfer;
    logic             tmr_load;
    logic [DLY_W-1:0] tmr_val;
    logic             tmr_expired;

    lcd_hex_seq #(
        .DLY_W     (DLY_W),
        .LONG_CYC  (LONG_CYC),
        .SHORT_CYC (SHORT_CYC)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .value       (value),
        .busy        (busy),
        .wr_go       (wr_go),
        .xfer        (xfer),
        .wr_done     (wr_done),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .tmr_expired (tmr_expired)
    );

    lcd_delay_timer #(
        .W (DLY_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    lcd_bus_writer #(
        .E_CYCLES (E_CYCLES)
    ) u_writer (
        .clk      (clk),
        .rst      (rst),
        .go       (wr_go),
        .xfer     (xfer),
        .busy     (wr_busy),
        .done     (wr_done),
        .lcd_e    (lcd_e),
        .lcd_rs   (lcd_rs),
        .lcd_data (lcd_data)
    );

    assign lcd_rw = 1'b0;

    // A write is only issued once the pause has run out and the bus is free
    p_issue_after_pause_r3: assert property (@(posedge clk) disable iff (rst)
        wr_go |-> (tmr_expired && !wr_busy));

    // No enable pulse during the power-up wait
    p_no_pulse_in_boot_r1: assert property (@(posedge clk) disable iff (rst)
        (!tmr_expired && !wr_busy) |-> !lcd_e);

endmodule

// File: tb/lcd_hex_ctrl_bench.sv
`timescale 1ns/1ps
module lcd_hex_ctrl_bench;

    localparam int CLK_HZ    = 100_000;
    localparam int LONG_MS   = 30;
    localparam int SHORT_MS  = 1;
    localparam int E_CYC     = 7;
    localparam int LONG_CYC  = CLK_HZ / 1000 * LONG_MS;
    localparam int SHORT_CYC = CLK_HZ / 1000 * SHORT_MS;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] value = '0;
    logic        busy, lcd_rs, lcd_rw, lcd_e;
    logic [7:0]  lcd_data;

    always #2 clk = ~clk;

    lcd_hex_ctrl #(
        .CLK_HZ   (CLK_HZ),
        .LONG_MS  (LONG_MS),
        .SHORT_MS (SHORT_MS),
        .E_CYCLES (E_CYC)
    ) u_lcd_hex_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .value    (value),
        .busy     (busy),
        .lcd_rs   (lcd_rs),
        .lcd_rw   (lcd_rw),
        .lcd_e    (lcd_e),
        .lcd_data (lcd_data)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_ascii(input logic [3:0] n);
        if (n < 4'd10) return 8'd48 + 8'(n);
        return 8'd65 + 8'(n) - 8'd10;
    endfunction

    // Pin monitor: records each enable pulse
    logic       cap_rs  [64];
    logic [7:0] cap_d   [64];
    int         cap_w   [64];
    int         cap_gap [64];
    int         n_wr, cyc, last_fall, hi_len;
    logic       pe, prs;
    logic [7:0] pd;
    bit         hold_chk;

    always @(negedge clk) begin
        if (rst) begin
            n_wr = 0; cyc = 0; last_fall = 0; hi_len = 0;
            pe = 1'b0; prs = lcd_rs; pd = lcd_data; hold_chk = 0;
        end else begin
            cyc++;
            if (hold_chk) begin
                chk((lcd_rs == prs) && (lcd_data == pd), "R5 hold after fall", lcd_data, pd);
                hold_chk = 0;
            end
            if (lcd_e && !pe) begin
                chk((lcd_rs == prs) && (lcd_data == pd), "R5 setup before rise", lcd_data, pd);
                if (n_wr < 64) cap_gap[n_wr] = cyc - last_fall;
                hi_len = 1;
            end else if (lcd_e && pe) begin
                hi_len++;
                if ((lcd_rs != prs) || (lcd_data != pd))
                    chk(1'b0, "R5 stable while high", lcd_data, pd);
            end else if (!lcd_e && pe) begin
                chk((lcd_rs == prs) && (lcd_data == pd), "R5 hold at fall", lcd_data, pd);
                if (n_wr < 64) begin
                    cap_rs[n_wr] = prs;
                    cap_d[n_wr]  = pd;
                    cap_w[n_wr]  = hi_len;
                end
                n_wr++;
                last_fall = cyc;
                hold_chk  = 1;
            end
            pe = lcd_e; prs = lcd_rs; pd = lcd_data;
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic send_value(input logic [15:0] v);
        @(negedge clk);
        value = v;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9 busy after accept", busy, 1);
    endtask

    task automatic check_value(input int base, input logic [15:0] v);
        chk(n_wr == base + 5, "R7 write count", n_wr - base, 5);
        chk(cap_rs[base] == 1'b0 && cap_d[base] == 8'h02, "R6 home instruction", {cap_rs[base], cap_d[base]}, 8'h02);
        chk(cap_gap[base + 1] >= LONG_CYC, "R6 long pause after home", cap_gap[base + 1], LONG_CYC);
        for (int k = 0; k < 4; k++) begin
            int i = base + 1 + k;
            logic [3:0] nib = 4'((v >> (12 - 4 * k)) & 16'hF);
            chk(cap_rs[i] == 1'b1, "R7 character select high", cap_rs[i], 1);
            chk(cap_d[i] == exp_ascii(nib), "R8 ascii digit", cap_d[i], exp_ascii(nib));
            chk(cap_w[i] == E_CYC, "R4 enable width", cap_w[i], E_CYC);
            if (k > 0) chk(cap_gap[i] >= SHORT_CYC, "R3 short pause", cap_gap[i], SHORT_CYC);
        end
        chk(cap_w[base] == E_CYC, "R4 enable width home", cap_w[base], E_CYC);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (5) @(negedge clk);
        chk(busy == 1'b1, "R1 busy in reset", busy, 1);
        chk(lcd_e == 1'b0, "R1 enable low in reset", lcd_e, 0);
        chk(lcd_rw == 1'b0, "R1 rw low", lcd_rw, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R1 busy during power-up wait", busy, 1);
        chk(lcd_e == 1'b0, "R1 enable low after reset", lcd_e, 0);
    endtask

    task automatic t_init();
        logic [7:0] cmds [4];
        cmds[0] = 8'h3C; cmds[1] = 8'h0F; cmds[2] = 8'h01; cmds[3] = 8'h06;
        wait_idle();
        chk(n_wr == 4, "R2 init write count", n_wr, 4);
        for (int i = 0; i < 4; i++) begin
            chk(cap_rs[i] == 1'b0, "R2 instruction select low", cap_rs[i], 0);
            chk(cap_d[i] == cmds[i], "R2 init byte", cap_d[i], cmds[i]);
            chk(cap_w[i] == E_CYC, "R4 enable width init", cap_w[i], E_CYC);
            if (i == 0) chk(cap_gap[0] >= LONG_CYC, "R1 power-up wait", cap_gap[0], LONG_CYC);
            else        chk(cap_gap[i] >= SHORT_CYC, "R3 init pause", cap_gap[i], SHORT_CYC);
        end
        chk(lcd_rw == 1'b0, "R1 rw low after init", lcd_rw, 0);
    endtask

    task automatic t_value(input logic [15:0] v);
        int base = n_wr;
        send_value(v);
        wait_idle();
        chk(busy == 1'b0, "R9 busy low when done", busy, 0);
        check_value(base, v);
    endtask

    task automatic t_ignore();
        int base = n_wr;
        send_value(16'h1B7E);
        repeat (20) @(negedge clk);
        value = 16'hC0D3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        check_value(base, 16'h1B7E);
        repeat (300) @(negedge clk);
        chk(n_wr == base + 5, "R10 no extra writes", n_wr - base, 5);
        chk(busy == 1'b0, "R10 stays idle", busy, 0);
    endtask

    initial begin
        t_reset();
        t_init();
        t_value(16'h9AF0);
        t_value(16'h0000);
        t_value(16'hFFFF);
        t_value(16'h1234);
        t_value(16'hA5C9);
        t_ignore();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0x%0h expected=0x%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule